// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block sits on the host side of a parallel NAND flash channel and erases one block per request. When the requester pulses a start input with a block number, the sequencer selects the device and issues a setup command. It then sends three address bytes that carry the row address, with the page-within-block bits forced to zero, and issues a confirm command. The device does not begin erasing until that confirm byte arrives, so the two commands together guard against an erase started by bus noise.

After the confirm strobe the sequencer waits a fixed guard interval before it looks at the ready/busy line. It then waits for the line to go high again, bounded by a busy-time limit. Once the device is ready it issues a status command and performs one read strobe. From the status byte it takes the pass/fail bit and the write-protect bit. The result goes back to the requester as a one-cycle done pulse, with fail, write-protect and timeout flags and the raw status byte.

Every command and address strobe uses the same timing pattern. CLE or ALE and the data byte are presented for a setup count, then WE is pulsed low for a pulse count, then everything is held for a hold count. All three counts are parameters.

Top module: `nand_erase_seq`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high (inactive), CLE and ALE are low, and busy_o and done_o are low.
- R2: A start issues exactly these strobe cycles, in this order: command 0x60, three address cycles, command 0xD0, command 0x70, and then one read strobe. Commands are latched with CLE high and ALE low. Addresses are latched with ALE high and CLE low.
- R3: The row address is the block number shifted left by PAGE_W (6) zero bits. The three address bytes carry row bits [7:0], then [15:8], then [23:16].
- R4: Every write strobe is low for exactly T_PULSE cycles. CLE or ALE is high for at least T_SETUP cycles before the strobe falls. The I/O byte does not change while the strobe is low.
- R5: CLE and ALE are never both high. The write and read strobes are never both low.
- R6: The status command's write strobe rises more than T_WB + T_SETUP + T_PULSE cycles after the confirm strobe rises, even when ready/busy never goes low. When the device does go busy, the status command is issued only after ready/busy has returned high.
- R7: Status bit 0 sets fail_o (1 = fail, 0 = pass). The status byte is reported on status_o.
- R8: Status bit 7 low sets wp_o, independently of fail_o.
- R9: If ready/busy stays low longer than T_BUSY_MAX cycles, the operation ends with timeout_o and fail_o high, and no status command is issued.
- R10: A start while busy_o is high is ignored. The address cycles carry the block latched at the original start, and only one done pulse occurs.
- R11: done_o is high for exactly one cycle per operation, and the flags are valid in that cycle.
- R12: Chip enable is low whenever a strobe is active and high once the operation has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| blk_addr_i | input | BLK_W | Block number to erase |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Erase failed or timed out |
| wp_o | output | 1 | Device reported write protection |
| timeout_o | output | 1 | Ready/busy stayed low past the limit |
| status_o | output | 8 | Status byte read from the device |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_io_o | output | 8 | I/O byte driven to the device |
| nand_io_oe_o | output | 1 | Output enable for nand_io_o |
| nand_io_i | input | 8 | I/O byte from the device |
| nand_rb_i | input | 1 | Ready/busy from the device, low while busy |

## Verification
The main flow is run against device responses that differ only in the status byte and in how ready/busy behaves.

- **Status bytes:** a pass byte, a fail byte and a protected byte show that the fail and write-protect bits are decoded separately.
- **Ready/busy:** a device that drops ready/busy for a long erase shows that status is polled only after ready returns. A device that never drops it shows that the guard interval is still observed. A device that never recovers shows the timeout path, with no status command issued.
- **Block numbers:** block numbers of all zeros, all ones and a mixed pattern separate the address byte order from the zeroed page bits.
- **Start while busy:** a second start in the middle of an operation shows that the latched block number survives.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

  typedef enum logic [1:0] {CYC_CMD, CYC_ADDR, CYC_READ} cyc_kind_e;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} cyc_phase_e;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_ADR0, S_ADR1, S_ADR2, S_CONF,
    S_WB, S_RDY, S_STCMD, S_STRD, S_DONE
  } seq_state_e;

  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS      = 8'h70;

  localparam int ST_FAIL_BIT = 0;
  localparam int ST_WPN_BIT  = 7;

endpackage

// File: rtl/nand_wait_cnt.sv
module nand_wait_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // an elapsed wait stays elapsed until reloaded
  assert_wait_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !load_i) |=> expired_o);

  // a running wait counts down by one each cycle
  assert_wait_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!expired_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_erase_pkg::*;
#(
  parameter int T_SETUP = 2,
  parameter int T_PULSE = 2,
  parameter int T_HOLD  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  cyc_kind_e  kind_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rd_data_o,
  output logic       cle_o,
  output logic       ale_o,
  output logic       we_no,
  output logic       re_no,
  output logic [7:0] io_o,
  output logic       io_oe_o,
  input  logic [7:0] io_i
);

  localparam int T_MAX = (T_SETUP > T_PULSE) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                             : ((T_PULSE > T_HOLD) ? T_PULSE : T_HOLD);
  localparam int PH_W  = (T_MAX < 2) ? 1 : $clog2(T_MAX);

  cyc_phase_e      phase_q;
  cyc_kind_e       kind_q;
  logic [7:0]      data_q;
  logic [7:0]      rd_q;
  logic [PH_W-1:0] cnt_q;
  logic            active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      kind_q  <= CYC_CMD;
      data_q  <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
    end else if (phase_q == PH_IDLE) begin
      if (go_i) begin
        phase_q <= PH_SETUP;
        kind_q  <= kind_i;
        data_q  <= data_i;
        cnt_q   <= PH_W'(T_SETUP - 1);
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      unique case (phase_q)
        PH_SETUP: begin
          phase_q <= PH_PULSE;
          cnt_q   <= PH_W'(T_PULSE - 1);
        end
        PH_PULSE: begin
          phase_q <= PH_HOLD;
          cnt_q   <= PH_W'(T_HOLD - 1);
          if (kind_q == CYC_READ) rd_q <= io_i;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign active    = (phase_q != PH_IDLE);
  assign busy_o    = active;
  assign done_o    = (phase_q == PH_HOLD) && (cnt_q == '0);
  assign rd_data_o = rd_q;
  assign cle_o     = active && (kind_q == CYC_CMD);
  assign ale_o     = active && (kind_q == CYC_ADDR);
  assign we_no     = !((phase_q == PH_PULSE) && (kind_q != CYC_READ));
  assign re_no     = !((phase_q == PH_PULSE) && (kind_q == CYC_READ));
  assign io_o      = data_q;
  assign io_oe_o   = active && (kind_q != CYC_READ);

  assert_latch_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));

  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));

  assert_io_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no && !$past(we_no)) |-> ($stable(io_o) && $stable(cle_o) && $stable(ale_o)));

  assert_setup_before_we_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_no) |-> $past(cle_o || ale_o));

endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nand_erase_pkg::*;
#(
  parameter int BLK_W      = 11,
  parameter int PAGE_W     = 6,
  parameter int T_SETUP    = 2,
  parameter int T_PULSE    = 2,
  parameter int T_HOLD     = 2,
  parameter int T_WB       = 8,
  parameter int T_BUSY_MAX = 2000000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BLK_W-1:0] blk_addr_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic             wp_o,
  output logic             timeout_o,
  output logic [7:0]       status_o,
  output logic             nand_ce_no,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_no,
  output logic             nand_re_no,
  output logic [7:0]       nand_io_o,
  output logic             nand_io_oe_o,
  input  logic [7:0]       nand_io_i,
  input  logic             nand_rb_i
);

  localparam int ROW_W    = BLK_W + PAGE_W;
  localparam int WAIT_MAX = (T_BUSY_MAX > T_WB) ? T_BUSY_MAX : T_WB;
  localparam int CNT_W    = $clog2(WAIT_MAX + 1);

  seq_state_e       state_q;
  logic [BLK_W-1:0] blk_q;
  logic             fail_q, wp_q, to_q;
  logic [7:0]       stat_q;
  logic [1:0]       rb_sync_q;
  logic             rb_ready;
  logic [23:0]      row_bytes;

  logic             cyc_go, cyc_busy, cyc_done, bus_state;
  cyc_kind_e        cyc_kind;
  logic [7:0]       cyc_data, rd_byte;

  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;

  // page bits inside the block are sent as zero
  assign row_bytes = 24'({blk_q, {PAGE_W{1'b0}}});
  assign rb_ready  = rb_sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rb_sync_q <= 2'b11;
    else         rb_sync_q <= {rb_sync_q[0], nand_rb_i};
  end

  always_comb begin
    bus_state = 1'b1;
    cyc_kind  = CYC_CMD;
    cyc_data  = '0;
    unique case (state_q)
      S_SETUP: cyc_data = OP_ERASE_SETUP;
      S_ADR0:  begin cyc_kind = CYC_ADDR; cyc_data = row_bytes[7:0];   end
      S_ADR1:  begin cyc_kind = CYC_ADDR; cyc_data = row_bytes[15:8];  end
      S_ADR2:  begin cyc_kind = CYC_ADDR; cyc_data = row_bytes[23:16]; end
      S_CONF:  cyc_data = OP_ERASE_GO;
      S_STCMD: cyc_data = OP_STATUS;
      S_STRD:  cyc_kind = CYC_READ;
      default: bus_state = 1'b0;
    endcase
  end

  assign cyc_go = bus_state && !cyc_busy;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (state_q == S_CONF && cyc_done) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(T_WB);
    end else if (state_q == S_WB && tmr_exp) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(T_BUSY_MAX);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      blk_q   <= '0;
      fail_q  <= 1'b0;
      wp_q    <= 1'b0;
      to_q    <= 1'b0;
      stat_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          blk_q   <= blk_addr_i;
          fail_q  <= 1'b0;
          wp_q    <= 1'b0;
          to_q    <= 1'b0;
          stat_q  <= '0;
          state_q <= S_SETUP;
        end
        S_SETUP: if (cyc_done) state_q <= S_ADR0;
        S_ADR0:  if (cyc_done) state_q <= S_ADR1;
        S_ADR1:  if (cyc_done) state_q <= S_ADR2;
        S_ADR2:  if (cyc_done) state_q <= S_CONF;
        S_CONF:  if (cyc_done) state_q <= S_WB;
        S_WB:    if (tmr_exp)  state_q <= S_RDY;
        S_RDY: begin
          if (rb_ready) begin
            state_q <= S_STCMD;
          end else if (tmr_exp) begin
            to_q    <= 1'b1;
            fail_q  <= 1'b1;
            state_q <= S_DONE;
          end
        end
        S_STCMD: if (cyc_done) state_q <= S_STRD;
        S_STRD: if (cyc_done) begin
          stat_q  <= rd_byte;
          fail_q  <= rd_byte[ST_FAIL_BIT];
          wp_q    <= !rd_byte[ST_WPN_BIT];
          state_q <= S_DONE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  nand_bus_cycle #(
    .T_SETUP (T_SETUP),
    .T_PULSE (T_PULSE),
    .T_HOLD  (T_HOLD)
  ) u_cycle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (cyc_go),
    .kind_i    (cyc_kind),
    .data_i    (cyc_data),
    .busy_o    (cyc_busy),
    .done_o    (cyc_done),
    .rd_data_o (rd_byte),
    .cle_o     (nand_cle_o),
    .ale_o     (nand_ale_o),
    .we_no     (nand_we_no),
    .re_no     (nand_re_no),
    .io_o      (nand_io_o),
    .io_oe_o   (nand_io_oe_o),
    .io_i      (nand_io_i)
  );

  nand_wait_cnt #(.W(CNT_W)) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (tmr_exp)
  );

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);
  assign fail_o     = fail_q;
  assign wp_o       = wp_q;
  assign timeout_o  = to_q;
  assign status_o   = stat_q;
  assign nand_ce_no = (state_q == S_IDLE);

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(blk_q));

  assert_strobe_selected_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> !nand_ce_no);

  assert_timeout_fails_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && timeout_o) |-> fail_o);

  assert_no_rd_while_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RDY && !rb_ready) |=> (nand_we_no && nand_re_no));

endmodule

// File: tb/nand_erase_seq_tb_top.sv
module nand_erase_seq_tb_top;

  localparam int BLK_W = 11, PAGE_W = 6;
  localparam int T_SETUP = 2, T_PULSE = 3, T_HOLD = 1, T_WB = 6, T_BUSY_MAX = 120;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [BLK_W-1:0] blk = '0;
  logic busy, done, fail, wp, tmo, ce_n, cle, ale, we_n, re_n, io_oe, rb;
  logic [7:0] status, io_out, io_in, stat_byte;

  always #10 clk = ~clk;

  assign io_in = re_n ? 8'hFF : stat_byte;

  nand_erase_seq #(.BLK_W(BLK_W), .PAGE_W(PAGE_W), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE),
                   .T_HOLD(T_HOLD), .T_WB(T_WB), .T_BUSY_MAX(T_BUSY_MAX)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .blk_addr_i(blk),
    .busy_o(busy), .done_o(done), .fail_o(fail), .wp_o(wp), .timeout_o(tmo),
    .status_o(status), .nand_ce_no(ce_n), .nand_cle_o(cle), .nand_ale_o(ale),
    .nand_we_no(we_n), .nand_re_no(re_n), .nand_io_o(io_out), .nand_io_oe_o(io_oe),
    .nand_io_i(io_in), .nand_rb_i(rb));

  int checks = 0, errors = 0;
  int cyc = 0;
  // strobe log
  logic       log_cle [16];
  logic       log_ale [16];
  logic [7:0] log_dat [16];
  int         log_cyc [16];
  int         log_n = 0, re_n_cnt = 0, done_cnt = 0;
  int         d0_cyc = -1, rb_rise_cyc = -1;
  int         v_pulse = 0, v_setup = 0, v_excl = 0, v_ce = 0;
  int         we_run = 0, ctl_run = 0;
  logic       prev_we = 1'b1, prev_re = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (cle && ale) v_excl++;
    if (!we_n && !re_n) v_excl++;
    if ((!we_n || !re_n) && ce_n) v_ce++;
    if (!we_n) we_run++;
    if (we_n && !prev_we) begin
      if (we_run != T_PULSE) v_pulse++;
      if (log_n < 16) begin
        log_cle[log_n] = cle; log_ale[log_n] = ale;
        log_dat[log_n] = io_out; log_cyc[log_n] = cyc;
      end
      if (cle && io_out == 8'hD0) d0_cyc = cyc;
      log_n++;
      we_run = 0;
    end
    if (!we_n && prev_we && ctl_run < T_SETUP) v_setup++;
    if ((cle || ale) && we_n) ctl_run++;
    else if (!(cle || ale)) ctl_run = 0;
    if (re_n && !prev_re) re_n_cnt++;
    if (done) done_cnt++;
    prev_we = we_n; prev_re = re_n;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // result of the last operation
  logic r_fail, r_wp, r_tmo, r_seen;
  logic [7:0] r_stat;

  // busy_len > 0: device busy that long; 0: never busy; < 0: stuck busy
  task automatic run_op(input logic [BLK_W-1:0] b, input logic [7:0] st,
                        input int busy_len, input bit inject);
    log_n = 0; re_n_cnt = 0; done_cnt = 0; d0_cyc = -1; rb_rise_cyc = -1;
    stat_byte = st; r_seen = 1'b0;
    @(negedge clk); start = 1'b1; blk = b;
    @(negedge clk); start = 1'b0; blk = ~b;
    for (int k = 0; k < 1500; k++) begin
      @(negedge clk);
      start = (inject && k == 12);
      if (d0_cyc >= 0 && busy_len != 0) begin
        int t = cyc - d0_cyc;
        logic nrb = (busy_len < 0) ? !(t >= 2) : !(t >= 2 && t < 2 + busy_len);
        if (nrb && !rb) rb_rise_cyc = cyc;
        rb = nrb;
      end
      if (done) begin
        r_seen = 1'b1; r_fail = fail; r_wp = wp; r_tmo = tmo; r_stat = status;
        break;
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk(!done, "R11 done single cycle", done, 0);
    rb = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_seq(input logic [BLK_W-1:0] b, input bit with_status);
    logic [23:0] row = 24'({b, {PAGE_W{1'b0}}});
    int n = with_status ? 6 : 5;
    chk(r_seen, "R11 done seen", r_seen, 1);
    chk(log_n == n, "R2 strobe count", log_n, n);
    if (log_n >= 5) begin
      chk(log_cle[0] && !log_ale[0] && log_dat[0] == 8'h60, "R2 setup cmd", log_dat[0], 8'h60);
      chk(!log_cle[1] && log_ale[1] && log_dat[1] == row[7:0], "R3 addr byte0", log_dat[1], row[7:0]);
      chk(!log_cle[2] && log_ale[2] && log_dat[2] == row[15:8], "R3 addr byte1", log_dat[2], row[15:8]);
      chk(!log_cle[3] && log_ale[3] && log_dat[3] == row[23:16], "R3 addr byte2", log_dat[3], row[23:16]);
      chk(log_cle[4] && !log_ale[4] && log_dat[4] == 8'hD0, "R2 confirm cmd", log_dat[4], 8'hD0);
    end
    if (with_status && log_n >= 6)
      chk(log_cle[5] && log_dat[5] == 8'h70, "R2 status cmd", log_dat[5], 8'h70);
    chk(re_n_cnt == (with_status ? 1 : 0), "R2 read strobes", re_n_cnt, with_status ? 1 : 0);
    chk(v_pulse == 0 && v_setup == 0, "R4 strobe timing", v_pulse + v_setup, 0);
    chk(v_excl == 0, "R5 exclusive strobes", v_excl, 0);
    chk(v_ce == 0 && ce_n && !busy, "R12 chip enable", {v_ce[7:0], ce_n, busy}, 2);
  endtask

  task automatic t_reset();
    chk(ce_n && we_n && re_n && !cle && !ale, "R1 bus idle", {ce_n, we_n, re_n, cle, ale}, 5'b11100);
    chk(!busy && !done, "R1 status idle", {busy, done}, 0);
  endtask

  task automatic t_pass();
    run_op(11'h5A3, 8'hC0, 40, 1'b0);
    check_seq(11'h5A3, 1'b1);
    chk(!r_fail && !r_wp && !r_tmo, "R7 pass flags", {r_fail, r_wp, r_tmo}, 0);
    chk(r_stat == 8'hC0, "R7 status byte", r_stat, 8'hC0);
    chk(rb_rise_cyc > 0 && log_n >= 6 && log_cyc[5] > rb_rise_cyc, "R6 status after ready",
        log_n >= 6 ? log_cyc[5] : 0, rb_rise_cyc);
  endtask

  task automatic t_fail();
    run_op(11'h000, 8'hC1, 25, 1'b0);
    check_seq(11'h000, 1'b1);
    chk(r_fail && !r_wp && !r_tmo, "R7 fail flag", {r_fail, r_wp, r_tmo}, 3'b100);
  endtask

  task automatic t_protect();
    run_op(11'h7FF, 8'h40, 10, 1'b0);
    check_seq(11'h7FF, 1'b1);
    chk(!r_fail && r_wp, "R8 protect flag", {r_fail, r_wp}, 2'b01);
  endtask

  task automatic t_fast_device();
    int gap;
    run_op(11'h2B4, 8'hC0, 0, 1'b0);
    check_seq(11'h2B4, 1'b1);
    gap = (log_n >= 6) ? log_cyc[5] - log_cyc[4] : 0;
    chk(gap > T_WB + T_SETUP + T_PULSE && gap < T_WB + T_SETUP + T_PULSE + T_HOLD + 10,
        "R6 guard interval", gap, T_WB + T_SETUP + T_PULSE + 1);
  endtask

  task automatic t_timeout();
    run_op(11'h155, 8'hC0, -1, 1'b0);
    check_seq(11'h155, 1'b0);
    chk(r_tmo && r_fail, "R9 timeout flags", {r_tmo, r_fail}, 2'b11);
  endtask

  task automatic t_busy_start();
    run_op(11'h3C9, 8'hC1, 30, 1'b1);
    check_seq(11'h3C9, 1'b1);
    chk(done_cnt == 1, "R10 single done", done_cnt, 1);
    chk(r_fail, "R10 result kept", r_fail, 1);
  endtask

  initial begin
    rb = 1'b1; stat_byte = 8'hFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_pass();
    t_fail();
    t_protect();
    t_fast_device();
    t_timeout();
    t_busy_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule